// File: doc/BRIEF.md
# Reset Sequence Manager

This block produces the internal reset for a small 8-bit microcontroller core. It also produces the strobe that marks the reset-vector fetch. A reset can come from two sources: an active-low external reset pin, or a one-cycle request from the watchdog timer. Either source starts a fixed sequence of three phases:

1. An active phase, whose form depends on the source.
2. A stabilisation delay, whose length an option input selects.
3. A two-cycle vector fetch.

After the fetch, the core is released. The reset pin is open-drain. The block pulls it low through its own pull-down enable during the whole delay phase, and also during the watchdog active phase.

The pin level is brought into the clock domain through a synchroniser. A width filter then accepts only pulses that last long enough. Pin lows that the block caused itself are masked, so the pull-down loops back through the pad without starting a new reset. A sticky status bit records that the last reset came from the watchdog. Software reads and clears this bit through a one-register port.

Top module: `rsm_top`

## Requirements
- R1: While `pwr_rst_n` is low, `core_rst` and `rst_pin_pulldown` are 1, `vec_fetch` is 0 and `reg_rdata` is 0. After `pwr_rst_n` is released, the block runs a delay phase and then a fetch phase.
- R2: The phases always run in the order active, delay, fetch, then run. `core_rst` is 1 in every phase except run.
- R3: The delay phase lasts 256 cycles when `long_delay_sel` is 0. It lasts 4096 cycles when `long_delay_sel` is 1.
- R4: `vec_fetch` is 1 for exactly 2 cycles, directly after the last delay cycle. `core_rst` is 0 in the cycle after the last fetch cycle.
- R5: `rst_pin_pulldown` is 1 in every delay cycle. It is 0 in the fetch and run phases.
- R6: The pin passes through a 2-flop synchroniser. It starts a reset only when its synchronised level is low for 4 consecutive cycles during run; a 3-cycle low pulse leaves every output unchanged. During the external active phase the block does not drive the pin. That phase ends when the synchronised pin reads high again.
- R7: A `wdg_fire` pulse starts an active phase with `rst_pin_pulldown` at 1 for 8 cycles. The delay phase follows it.
- R8: `reg_rdata` bit 0 is the watchdog-cause flag, and a `wdg_fire` pulse sets it. Bits 7:1 read as 0.
- R9: A `reg_wr` with `reg_wdata` bit 0 at 0 clears the flag. A write with bit 0 at 1 has no effect. A `wdg_fire` in the same cycle as a clearing write wins. The reset sequence itself does not clear the flag.
- R10: A `wdg_fire` during the delay or fetch phase restarts the sequence at the watchdog active phase.
- R11: A pin low caused by the block's own pull-down is never taken as an external request. This covers the delay phase and the synchroniser flush window after the pull-down is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| pwr_rst_n | input | 1 | Asynchronous power-on reset of the sequencer's own flops, active low |
| rst_pin_n | input | 1 | Sensed level of the open-drain reset pin, active low |
| wdg_fire | input | 1 | One-cycle reset request from the watchdog |
| long_delay_sel | input | 1 | Option: 0 selects the short delay, 1 the long delay |
| reg_wr | input | 1 | Write strobe for the status register |
| reg_wdata | input | 8 | Status register write data; only bit 0 is used |
| reg_rdata | output | 8 | Status register read data: bit 0 is the watchdog flag |
| core_rst | output | 1 | Internal reset to the core, active high |
| vec_fetch | output | 1 | High during the reset-vector fetch phase |
| rst_pin_pulldown | output | 1 | Enables the open-drain pull-down on the reset pin |

## Verification
The assertions check on every cycle the behaviour that does not depend on how long the sequence has been running:
- the fetch phase is only entered straight from a pin-driving phase;
- the core is released right after the fetch;
- the watchdog active phase holds until its count ends;
- a watchdog pulse always restarts the sequence;
- the flag follows its set and clear rules;
- a filtered external request is always preceded by a low synchronised pin.

Only the bench scenarios can show the absolute phase lengths (256 and 4096 delay cycles, the 8-cycle watchdog pulse, the 2-cycle fetch), the rejection of a pulse one cycle too short, and the absence of self-triggering when the pull-down loops back through the pin. The bench compares all outputs on every cycle against a behavioural model, and measures these lengths directly.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
   typedef enum logic [2:0] {
      PH_RUN     = 3'd0,
      PH_ACT_EXT = 3'd1,
      PH_ACT_WDG = 3'd2,
      PH_DELAY   = 3'd3,
      PH_FETCH   = 3'd4
   } rsm_phase_e;
endpackage

// File: rtl/rsm_pin_sync.sv
module rsm_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic pwr_rst_n,
   input  logic pin_n,
   output logic pin_sync_n
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rsm_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge pwr_rst_n) begin
            if (!pwr_rst_n) chain[0] <= 1'b1;
            else            chain[0] <= pin_n;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge pwr_rst_n) begin
            if (!pwr_rst_n) chain[i] <= 1'b1;
            else            chain[i] <= chain[i-1];
         end
      end
   end

   assign pin_sync_n = chain[STAGES-1];
endmodule

// File: rtl/rsm_ext_filter.sv
module rsm_ext_filter #(
   parameter int MIN_W = 4,
   parameter int HIST  = 2
) (
   input  logic clk,
   input  logic pwr_rst_n,
   input  logic pin_sync_n,
   input  logic armed,
   input  logic drive_low,
   output logic ext_hit
);
   if (MIN_W < 1) begin : g_bad_min
      $error("rsm_ext_filter: MIN_W must be at least 1");
   end
   if (HIST < 1) begin : g_bad_hist
      $error("rsm_ext_filter: HIST must be at least 1");
   end

   // Remember recent self-driven cycles so the flush of the synchroniser is masked (R11).
   logic [HIST-1:0] drv_hist;
   logic            det_en;

   if (HIST == 1) begin : g_hist1
      always_ff @(posedge clk or negedge pwr_rst_n) begin
         if (!pwr_rst_n) drv_hist <= '1;
         else            drv_hist <= drive_low;
      end
   end else begin : g_histn
      always_ff @(posedge clk or negedge pwr_rst_n) begin
         if (!pwr_rst_n) drv_hist <= '1;
         else            drv_hist <= {drv_hist[HIST-2:0], drive_low};
      end
   end

   assign det_en = armed && (drv_hist == '0);

   if (MIN_W == 1) begin : g_no_count
      assign ext_hit = det_en && !pin_sync_n;
   end else begin : g_count
      localparam int CW = $clog2(MIN_W);
      localparam logic [CW-1:0] LAST = CW'(MIN_W - 1);
      logic [CW-1:0] low_cnt;
      logic          low_now;

      assign low_now = det_en && !pin_sync_n;
      assign ext_hit = low_now && (low_cnt == LAST);

      always_ff @(posedge clk or negedge pwr_rst_n) begin
         if (!pwr_rst_n)             low_cnt <= '0;
         else if (low_now && !ext_hit) low_cnt <= low_cnt + 1'b1;
         else                        low_cnt <= '0;
      end

      // R6: an accepted request was already low and armed one cycle earlier
      a_r6_hit_after_low: assert property (@(posedge clk) disable iff (!pwr_rst_n)
         ext_hit |-> $past(!pin_sync_n && armed));
   end
endmodule

// File: rtl/rsm_phase_fsm.sv
module rsm_phase_fsm
   import rsm_pkg::*;
#(
   parameter int DLY_SHORT = 256,
   parameter int DLY_LONG  = 4096,
   parameter int WDG_PULSE = 8,
   parameter int FETCH_CYC = 2
) (
   input  logic       clk,
   input  logic       pwr_rst_n,
   input  logic       wdg_fire,
   input  logic       ext_hit,
   input  logic       pin_sync_n,
   input  logic       long_sel,
   output rsm_phase_e phase
);
   localparam int MAXC  = (DLY_LONG > DLY_SHORT) ? DLY_LONG : DLY_SHORT;
   localparam int MAXA  = (WDG_PULSE > FETCH_CYC) ? WDG_PULSE : FETCH_CYC;
   localparam int CNT_W = $clog2(((MAXC > MAXA) ? MAXC : MAXA) + 1);
   localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(DLY_SHORT - 1);
   localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(DLY_LONG - 1);
   localparam logic [CNT_W-1:0] WDG_LAST   = CNT_W'(WDG_PULSE - 1);
   localparam logic [CNT_W-1:0] FETCH_LAST = CNT_W'(FETCH_CYC - 1);

   if (DLY_SHORT < 1 || DLY_LONG < DLY_SHORT) begin : g_bad_dly
      $error("rsm_phase_fsm: need 1 <= DLY_SHORT <= DLY_LONG");
   end
   if (WDG_PULSE < 1 || FETCH_CYC < 1) begin : g_bad_len
      $error("rsm_phase_fsm: WDG_PULSE and FETCH_CYC must be at least 1");
   end

   rsm_phase_e      phase_q, phase_d;
   logic [CNT_W-1:0] ph_cnt, ph_cnt_d;
   logic [CNT_W-1:0] dly_last;

   assign dly_last = long_sel ? LONG_LAST : SHORT_LAST;

   always_comb begin
      phase_d  = phase_q;
      ph_cnt_d = ph_cnt + 1'b1;
      if (wdg_fire) begin
         phase_d  = PH_ACT_WDG;
         ph_cnt_d = '0;
      end else begin
         unique case (phase_q)
            PH_RUN: begin
               ph_cnt_d = '0;
               if (ext_hit) phase_d = PH_ACT_EXT;
            end
            PH_ACT_EXT: begin
               ph_cnt_d = '0;
               if (pin_sync_n) phase_d = PH_DELAY;
            end
            PH_ACT_WDG: if (ph_cnt == WDG_LAST) begin
               phase_d  = PH_DELAY;
               ph_cnt_d = '0;
            end
            PH_DELAY: if (ph_cnt == dly_last) begin
               phase_d  = PH_FETCH;
               ph_cnt_d = '0;
            end
            PH_FETCH: if (ph_cnt == FETCH_LAST) begin
               phase_d  = PH_RUN;
               ph_cnt_d = '0;
            end
            default: begin
               phase_d  = PH_RUN;
               ph_cnt_d = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge pwr_rst_n) begin
      if (!pwr_rst_n) begin
         phase_q <= PH_DELAY;
         ph_cnt  <= '0;
      end else begin
         phase_q <= phase_d;
         ph_cnt  <= ph_cnt_d;
      end
   end

   assign phase = phase_q;

   // R7: the watchdog active phase is held until its count is reached
   a_r7_wdg_hold: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (phase_q == PH_ACT_WDG && ph_cnt != WDG_LAST && !wdg_fire) |=> phase_q == PH_ACT_WDG);
   // R3: the delay phase is not left early
   a_r3_delay_hold: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (phase_q == PH_DELAY && ph_cnt != dly_last && !wdg_fire) |=> phase_q == PH_DELAY);
   // R10: a watchdog request always restarts at the watchdog active phase
   a_r10_restart: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      wdg_fire |=> (phase_q == PH_ACT_WDG && ph_cnt == '0));
endmodule

// File: rtl/rsm_status_reg.sv
module rsm_status_reg #(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             pwr_rst_n,
   input  logic             wdg_fire,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata
);
   if (REG_W < 2) begin : g_bad_w
      $error("rsm_status_reg: REG_W must be at least 2");
   end

   logic wdg_flag;
   logic unused_wdata;

   assign unused_wdata = ^reg_wdata[REG_W-1:1];

   always_ff @(posedge clk or negedge pwr_rst_n) begin
      if (!pwr_rst_n)                    wdg_flag <= 1'b0;
      else if (wdg_fire)                 wdg_flag <= 1'b1;
      else if (reg_wr && !reg_wdata[0])  wdg_flag <= 1'b0;
   end

   assign reg_rdata = {{(REG_W-1){1'b0}}, wdg_flag};

   // R8: a watchdog request is recorded
   a_r8_flag_set: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      wdg_fire |=> wdg_flag);
   // R9: a clearing write without a competing request clears the flag
   a_r9_flag_clear: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (reg_wr && !reg_wdata[0] && !wdg_fire) |=> !wdg_flag);
   // R9: nothing but a clearing write drops the flag
   a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (wdg_flag && !(reg_wr && !reg_wdata[0])) |=> wdg_flag);
endmodule

// File: rtl/rsm_top.sv
module rsm_top
   import rsm_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_EXT_W   = 4,
   parameter int WDG_PULSE   = 8,
   parameter int DLY_SHORT   = 256,
   parameter int DLY_LONG    = 4096,
   parameter int FETCH_CYC   = 2,
   parameter int REG_W       = 8
) (
   input  logic             clk,
   input  logic             pwr_rst_n,
   input  logic             rst_pin_n,
   input  logic             wdg_fire,
   input  logic             long_delay_sel,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             core_rst,
   output logic             vec_fetch,
   output logic             rst_pin_pulldown
);
   logic       pin_sync_n;
   logic       ext_hit;
   rsm_phase_e phase;

   rsm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .pwr_rst_n(pwr_rst_n), .pin_n(rst_pin_n), .pin_sync_n(pin_sync_n)
   );

   rsm_ext_filter #(.MIN_W(MIN_EXT_W), .HIST(SYNC_STAGES)) u_filt (
      .clk(clk), .pwr_rst_n(pwr_rst_n), .pin_sync_n(pin_sync_n),
      .armed(phase == PH_RUN), .drive_low(rst_pin_pulldown), .ext_hit(ext_hit)
   );

   rsm_phase_fsm #(
      .DLY_SHORT(DLY_SHORT), .DLY_LONG(DLY_LONG),
      .WDG_PULSE(WDG_PULSE), .FETCH_CYC(FETCH_CYC)
   ) u_fsm (
      .clk(clk), .pwr_rst_n(pwr_rst_n), .wdg_fire(wdg_fire), .ext_hit(ext_hit),
      .pin_sync_n(pin_sync_n), .long_sel(long_delay_sel), .phase(phase)
   );

   rsm_status_reg #(.REG_W(REG_W)) u_stat (
      .clk(clk), .pwr_rst_n(pwr_rst_n), .wdg_fire(wdg_fire),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   assign core_rst         = (phase != PH_RUN);
   assign vec_fetch        = (phase == PH_FETCH);
   assign rst_pin_pulldown = (phase == PH_ACT_WDG) || (phase == PH_DELAY);

   // R2: the fetch phase is only entered straight from a pin-driving phase
   a_r2_fetch_after_drive: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      $rose(vec_fetch) |-> $past(rst_pin_pulldown));
   // R4: the core is released right after the fetch unless the watchdog intervened
   a_r4_release: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      ($fell(vec_fetch) && !$past(wdg_fire)) |-> !core_rst);
   // R5: the pin is never driven during the fetch
   a_r5_no_drive_fetch: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      vec_fetch |-> !rst_pin_pulldown);
endmodule

// File: tb/tb_rsm_top.sv
module tb_rsm_top;
   localparam int MIN_W = 4;
   localparam int WDG_P = 8;
   localparam int DS    = 256;
   localparam int DL    = 4096;
   localparam int FC    = 2;

   logic       clk = 1'b0;
   logic       pwr_rst_n = 1'b0;
   logic       ext_low = 1'b0;
   logic       wdg_fire = 1'b0;
   logic       long_delay_sel = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       core_rst, vec_fetch, rst_pin_pulldown;
   logic       rst_pin_n;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   // open-drain pad: low when either the outside world or the block pulls it
   assign rst_pin_n = !(ext_low || rst_pin_pulldown);

   rsm_top dut (
      .clk(clk), .pwr_rst_n(pwr_rst_n), .rst_pin_n(rst_pin_n), .wdg_fire(wdg_fire),
      .long_delay_sel(long_delay_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .core_rst(core_rst), .vec_fetch(vec_fetch),
      .rst_pin_pulldown(rst_pin_pulldown)
   );

   // behavioural reference model: 0 run, 1 ext active, 2 wdg active, 3 delay, 4 fetch
   int m_st, m_ph, m_lc;
   bit m_s1, m_s2, m_h0, m_h1, m_flag;

   always @(posedge clk or negedge pwr_rst_n) begin
      if (!pwr_rst_n) begin
         m_st = 3; m_ph = 0; m_lc = 0;
         m_s1 = 1; m_s2 = 1; m_h0 = 1; m_h1 = 1; m_flag = 0;
      end else begin
         bit pd, pin, den, low, hit;
         int nst, nph, lim;
         pd  = (m_st == 2) || (m_st == 3);
         pin = !(ext_low || pd);
         den = (m_st == 0) && !m_h0 && !m_h1;
         low = den && !m_s2;
         hit = low && (m_lc == MIN_W - 1);
         lim = long_delay_sel ? DL : DS;
         nst = m_st; nph = m_ph + 1;
         if (wdg_fire) begin nst = 2; nph = 0; end
         else if (m_st == 0) begin nph = 0; if (hit) nst = 1; end
         else if (m_st == 1) begin nph = 0; if (m_s2) nst = 3; end
         else if (m_st == 2) begin if (m_ph == WDG_P - 1) begin nst = 3; nph = 0; end end
         else if (m_st == 3) begin if (m_ph == lim - 1) begin nst = 4; nph = 0; end end
         else begin if (m_ph == FC - 1) begin nst = 0; nph = 0; end end
         if (wdg_fire) m_flag = 1;
         else if (reg_wr && !reg_wdata[0]) m_flag = 0;
         m_lc = (low && !hit) ? m_lc + 1 : 0;
         m_h1 = m_h0; m_h0 = pd;
         m_s2 = m_s1; m_s1 = pin;
         m_st = nst; m_ph = nph;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      chk(core_rst == (m_st != 0), "R2 core_rst", core_rst, m_st != 0);
      chk(vec_fetch == (m_st == 4), "R4 vec_fetch", vec_fetch, m_st == 4);
      chk(rst_pin_pulldown == (m_st == 2 || m_st == 3), "R5 pulldown",
          rst_pin_pulldown, m_st == 2 || m_st == 3);
      chk(reg_rdata == {7'b0, m_flag}, "R8 reg_rdata", reg_rdata, m_flag);
   end

   task automatic measure(output int pdc, output int vfc);
      pdc = 0; vfc = 0;
      for (int i = 0; i < 6000 && core_rst; i++) begin
         if (rst_pin_pulldown) pdc++;
         if (vec_fetch) vfc++;
         @(negedge clk);
      end
   endtask

   task automatic pulse_wdg();
      wdg_fire = 1'b1;
      @(negedge clk);
      wdg_fire = 1'b0;
   endtask

   task automatic idle_check(input string req);
      repeat (10) @(negedge clk);
      chk(core_rst == 0, req, core_rst, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int pdc, vfc;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(core_rst && rst_pin_pulldown && !vec_fetch && reg_rdata == 0, "R1 reset state",
          {core_rst, rst_pin_pulldown, vec_fetch}, 3'b110);
      pwr_rst_n = 1'b1;
      measure(pdc, vfc);
      chk(pdc == DS, "R1 R3 power-on delay", pdc, DS);
      chk(vfc == FC, "R4 power-on fetch", vfc, FC);
      idle_check("R11 no self retrigger after power-on");

      // R6 short pulse ignored
      ext_low = 1'b1;
      repeat (MIN_W - 1) @(negedge clk);
      ext_low = 1'b0;
      repeat (10) @(negedge clk);
      chk(core_rst == 0 && reg_rdata == 0, "R6 short pulse ignored", core_rst, 0);

      // R6 long pulse accepted
      ext_low = 1'b1;
      repeat (MIN_W + 2) @(negedge clk);
      ext_low = 1'b0;
      chk(core_rst == 1 && rst_pin_pulldown == 0, "R6 ext active no drive", core_rst, 1);
      measure(pdc, vfc);
      chk(pdc == DS, "R6 R5 ext delay driven", pdc, DS);
      chk(vfc == FC, "R4 ext fetch", vfc, FC);
      chk(reg_rdata == 0, "R8 ext does not set flag", reg_rdata, 0);
      idle_check("R11 loopback ignored");

      // R7 watchdog with long delay
      long_delay_sel = 1'b1;
      pulse_wdg();
      measure(pdc, vfc);
      chk(pdc == WDG_P + DL, "R7 R3 wdg long", pdc, WDG_P + DL);
      chk(vfc == FC, "R4 wdg fetch", vfc, FC);
      chk(reg_rdata == 8'h01, "R8 flag set", reg_rdata, 1);
      chk(reg_rdata == 8'h01, "R9 flag survives sequence", reg_rdata, 1);
      long_delay_sel = 1'b0;

      // R9 write 1 has no effect, write 0 clears
      reg_wr = 1'b1; reg_wdata = 8'hFF;
      @(negedge clk);
      reg_wr = 1'b0;
      chk(reg_rdata == 8'h01, "R9 write one kept", reg_rdata, 1);
      reg_wr = 1'b1; reg_wdata = 8'hFE;
      @(negedge clk);
      reg_wr = 1'b0;
      chk(reg_rdata == 8'h00, "R9 write zero clears", reg_rdata, 0);

      // R9 set wins over clear
      reg_wr = 1'b1; reg_wdata = 8'h00;
      pulse_wdg();
      reg_wr = 1'b0;
      chk(reg_rdata == 8'h01, "R9 set wins", reg_rdata, 1);
      measure(pdc, vfc);
      chk(pdc == WDG_P + DS, "R7 wdg short", pdc, WDG_P + DS);

      // R10 restart during delay
      pulse_wdg();
      repeat (20) @(negedge clk);
      pulse_wdg();
      measure(pdc, vfc);
      chk(pdc == WDG_P + DS, "R10 restart in delay", pdc, WDG_P + DS);

      // R10 restart during fetch
      pulse_wdg();
      for (int i = 0; i < 400 && !vec_fetch; i++) @(negedge clk);
      chk(vec_fetch == 1, "R4 fetch reached", vec_fetch, 1);
      pulse_wdg();
      chk(vec_fetch == 0 && rst_pin_pulldown == 1, "R10 restart in fetch",
          {vec_fetch, rst_pin_pulldown}, 2'b01);
      measure(pdc, vfc);
      chk(pdc == WDG_P + DS, "R10 full sequence after restart", pdc, WDG_P + DS);
      idle_check("R11 quiet at end");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule